// File: doc/BRIEF.md
# Serial Program Loader

This block fills a 16-bit-wide program store from a slow bit-serial stream while the processor is held in reset. All of its logic runs on the serial load clock. While the device reset input is low, a short run of high bits on the data line arms a fresh transfer and clears the write address. A single low bit then marks the start of the stream. After that, every bit is data: each 16 bits form one word, which goes out on a write port of address, data and a one-cycle write strobe.

A rising edge on the load-done line closes the transfer. The processor may run from the loaded store once that edge has been seen and the device reset is released, and the block signals this on its run-enable output. The count of words written is always visible on the ports. Writes past the end of the address space are dropped and reported by a sticky overflow flag. A separate power-on reset puts the block into its armed, idle state.

Top module: `prog_loader`

## Requirements
- R1: Data is sampled on the rising edge of `clk`, most significant bit first. Once the 16th bit of a word has been sampled, `wr_en` is high for exactly one cycle with `wr_data` holding the assembled word.
- R2: Nothing is loaded while `rst_n` is high. Bits and word boundaries presented then cause no write and leave `word_cnt` unchanged.
- R3: In the armed state with `rst_n` low, `sdin` sampled high on two consecutive clocks clears the address, `word_cnt` and `ovf` on the second of those edges. A single high bit between low bits clears nothing.
- R4: After the clear, the first sampled low bit is a start marker and is not stored. From then on every bit is data, so words such as 16'hFFFF are stored and never clear the address.
- R5: Words are written to addresses 0, 1, 2, ... in order. `word_cnt` equals the number of words written since the last clear, and `wr_addr` equals `word_cnt` minus one whenever `wr_en` is high.
- R6: A rising edge of `ldone` sampled while `rst_n` is low ends the transfer. A partly assembled word is discarded, and data bits that follow cause no write.
- R7: `run_en` is high only when the transfer has ended and `rst_n` is high. It falls in the same cycle that `rst_n` goes low, and the loader is then armed again. `rst_n` going high without a completed transfer leaves `run_en` low.
- R8: Once 2**AW words have been written, further completed words are not written. `ovf` goes high and stays high, with `word_cnt` held at 2**AW, until the next clear.
- R9: While `por_n` is low, `wr_en`, `run_en` and `ovf` are low and `word_cnt` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial load clock; data sampled on its rising edge |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_n | input | 1 | Device reset, active low; loading allowed only while low |
| sdin | input | 1 | Serial program data |
| ldone | input | 1 | Load-done line; a rising edge ends the transfer |
| wr_en | output | 1 | One-cycle write strobe to the program store |
| wr_addr | output | AW (13) | Write address |
| wr_data | output | DW (16) | Write data |
| word_cnt | output | AW+1 (14) | Number of words written since the last clear |
| ovf | output | 1 | Sticky flag: a word was dropped because the store was full |
| run_en | output | 1 | Processor may execute from the program store |

## Verification
The write strobe, data, address, word count and overflow flag are all registered. Each is due on the rising edge that samples the 16th bit of a word, or, for the clear, the second high bit. The bench advances exactly one edge per bit and reads the outputs two nanoseconds after that edge, so every word is checked in the cycle its strobe is high. `run_en` is combinational in `rst_n`, so it is checked one nanosecond after `rst_n` changes, with no clock edge in between. The end of a transfer takes effect one edge after `ldone` rises and is checked after that edge.

// File: rtl/prog_loader.sv
`timescale 1ns/1ps
module prog_loader #(
  parameter int AW = 13,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          rst_n,
  input  logic          sdin,
  input  logic          ldone,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic [AW:0]   word_cnt,
  output logic          ovf,
  output logic          run_en
);
  localparam int BW = $clog2(DW);

  typedef enum logic [2:0] {ARMED, SYNC, DATA, DONE, RUN} st_t;

  st_t           st;
  logic          one_q, ldone_q;
  logic [BW-1:0] bit_cnt;
  logic [DW-2:0] shreg;
  logic [AW:0]   addr;

  wire loading = ~rst_n;
  wire ld_rise = ldone & ~ldone_q;

  assign word_cnt = addr;
  assign run_en   = rst_n & ((st == DONE) | (st == RUN));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st      <= ARMED;
      one_q   <= 1'b0;
      ldone_q <= 1'b0;
      bit_cnt <= '0;
      shreg   <= '0;
      addr    <= '0;
      ovf     <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      ldone_q <= ldone;
      wr_en   <= 1'b0;
      case (st)
        ARMED: begin
          one_q <= loading & sdin;
          if (loading && ld_rise) begin
            st <= DONE;
          end else if (loading && sdin && one_q) begin
            addr <= '0;
            ovf  <= 1'b0;
            st   <= SYNC;
          end
        end
        SYNC: if (loading) begin
          if (ld_rise) st <= DONE;
          else if (!sdin) begin
            bit_cnt <= '0;
            st      <= DATA;
          end
        end
        DATA: if (loading) begin
          if (ld_rise) begin
            st <= DONE;
          end else begin
            shreg   <= {shreg[DW-3:0], sdin};
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == BW'(DW-1)) begin
              bit_cnt <= '0;
              if (addr[AW]) begin
                ovf <= 1'b1;
              end else begin
                wr_en   <= 1'b1;
                wr_data <= {shreg, sdin};
                wr_addr <= addr[AW-1:0];
                addr    <= addr + 1'b1;
              end
            end
          end
        end
        DONE: if (rst_n) st <= RUN;
        RUN: if (!rst_n) begin
          one_q <= 1'b0;
          st    <= ARMED;
        end
        default: st <= ARMED;
      endcase
    end
  end
endmodule

module prog_loader_chk #(
  parameter int AW = 13
) (
  input logic          clk,
  input logic          por_n,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [AW:0]   word_cnt,
  input logic          ovf,
  input logic          run_en
);
  // R1
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!por_n) wr_en |=> !wr_en);
  // R2
  wr_in_reset_chk: assert property (@(posedge clk) disable iff (!por_n) wr_en |-> $past(!rst_n));
  // R5
  wr_addr_chk: assert property (@(posedge clk) disable iff (!por_n)
    wr_en |-> (word_cnt == ({1'b0, wr_addr} + 1'b1)));
  // R7
  run_gate_chk: assert property (@(posedge clk) disable iff (!por_n) run_en |-> rst_n);
  // R8
  ovf_full_chk: assert property (@(posedge clk) disable iff (!por_n)
    ovf |-> (word_cnt[AW] && word_cnt[AW-1:0] == '0));
  // R8
  cnt_range_chk: assert property (@(posedge clk) disable iff (!por_n)
    word_cnt[AW] |-> (word_cnt[AW-1:0] == '0));
  // R9
  por_idle_chk: assert property (@(posedge clk) !por_n |-> (!wr_en && !ovf && !run_en && word_cnt == '0));
endmodule

bind prog_loader prog_loader_chk #(.AW(AW)) u_prog_loader_chk (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .word_cnt(word_cnt), .ovf(ovf), .run_en(run_en)
);

// File: tb/test_prog_loader.sv
`timescale 1ns/1ps
module test_prog_loader;
  localparam int AW = 5;
  localparam int DW = 16;
  localparam int NV = 8;
  localparam int DEPTH = 1 << AW;
  localparam logic [DW-1:0] VEC [NV] = '{16'hFFFF, 16'hFFFE, 16'h0000, 16'h7FFF,
                                          16'hA5C3, 16'h8001, 16'h1234, 16'hFFFF};

  logic clk = 1'b0, por_n = 1'b0, rst_n = 1'b0, sdin = 1'b0, ldone = 1'b0;
  logic          wr_en, ovf, run_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [AW:0]   word_cnt;

  logic [DW-1:0] mem [DEPTH];
  int wr_total = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  prog_loader #(.AW(AW), .DW(DW)) i_prog_loader (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .sdin(sdin), .ldone(ldone),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .word_cnt(word_cnt), .ovf(ovf), .run_en(run_en)
  );

  always @(negedge clk) if (wr_en === 1'b1) begin
    mem[wr_addr] <= wr_data;
    wr_total <= wr_total + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    sdin = b;
    @(posedge clk);
    #2;
  endtask

  task automatic send_word(input logic [DW-1:0] w);
    for (int i = DW - 1; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int base;
    repeat (3) @(posedge clk);
    #2;
    chk("R9 wr_en", wr_en, 0);
    chk("R9 run_en", run_en, 0);
    chk("R9 ovf", ovf, 0);
    chk("R9 word_cnt", word_cnt, 0);
    por_n = 1'b1;
    @(posedge clk); #2;

    send_bit(1); send_bit(1);
    chk("R3 cleared", word_cnt, 0);
    send_bit(1);
    send_bit(0);
    for (int k = 0; k < NV; k++) begin
      send_word(VEC[k]);
      chk("R1 wr_en", wr_en, 1);
      chk("R1 wr_data", wr_data, VEC[k]);
      chk("R5 wr_addr", wr_addr, k);
      chk("R4 word_cnt", word_cnt, k + 1);
    end
    send_bit(1);
    chk("R1 strobe one cycle", wr_en, 0);
    repeat (4) send_bit(1);
    ldone = 1'b1;
    @(posedge clk); #2;
    chk("R6 partial dropped", word_cnt, NV);
    chk("R7 run_en held in reset", run_en, 0);
    for (int i = 0; i < 20; i++) send_bit(i[0]);
    chk("R6 no write after done", wr_total, NV);
    ldone = 1'b0;
    for (int k = 0; k < NV; k++) chk("R1 R5 stored word", mem[k], VEC[k]);

    rst_n = 1'b1; #1;
    chk("R7 run_en on release", run_en, 1);
    @(posedge clk); #2;
    repeat (3) send_word(16'hFFFF);
    chk("R2 no writes in run", wr_total, NV);
    chk("R2 count kept", word_cnt, NV);
    chk("R7 run_en stays", run_en, 1);
    rst_n = 1'b0; #1;
    chk("R7 run_en drops", run_en, 0);
    @(posedge clk); #2;

    send_bit(0); send_bit(1); send_bit(0); send_bit(1); send_bit(0);
    chk("R3 single high no clear", word_cnt, NV);
    send_bit(1); send_bit(1);
    chk("R3 clear count", word_cnt, 0);
    chk("R3 ovf clear", ovf, 0);

    rst_n = 1'b1; #1;
    chk("R7 no run without done", run_en, 0);
    repeat (20) send_bit(0);
    chk("R2 no writes while high", wr_total, NV);
    rst_n = 1'b0;
    send_bit(0);
    base = wr_total;
    for (int k = 0; k < DEPTH; k++) send_word(16'h0100 + DW'(k));
    chk("R8 full count", word_cnt, DEPTH);
    chk("R8 no ovf yet", ovf, 0);
    send_word(16'hBEEF);
    chk("R8 ovf set", ovf, 1);
    chk("R8 dropped strobe", wr_en, 0);
    chk("R8 count held", word_cnt, DEPTH);
    chk("R8 writes", wr_total - base, DEPTH);
    chk("R5 first addr", mem[0], 16'h0100);
    chk("R5 last addr", mem[DEPTH-1], 16'h0100 + DEPTH - 1);
    send_word(16'h1111);
    chk("R8 ovf sticky", ovf, 1);

    ldone = 1'b1;
    @(posedge clk); #2;
    ldone = 1'b0;
    rst_n = 1'b1; #1;
    chk("R7 run after overflow load", run_en, 1);
    @(posedge clk); #2;
    rst_n = 1'b0;
    @(posedge clk); #2;
    send_bit(1); send_bit(1);
    chk("R8 ovf cleared by clear", ovf, 0);
    chk("R3 count cleared again", word_cnt, 0);
    summary();
  end
endmodule